// File: doc/BRIEF.md
# Multiply-Accumulate Unit with 64-bit Accumulator

This block keeps a 64-bit running sum, split into a high and a low 32-bit half. It folds in signed products of two 32-bit operands, or of one operand and a sign-extended 16-bit immediate, by adding or subtracting them. Before it is widened to 64 bits, each product is cut to its low 32 bits and read as a signed value. A read-and-clear command returns the low half and zeroes the whole sum.

The multiplier output is held in one register stage. As a result, a read-and-clear that arrives while a product is still waiting to be added is held off with `op_ready` low. A plain write port loads either half on its own, and both halves are always visible on output ports.

Top module: `mac_acc`

## Requirements
- R1: Op code 1 (accumulate) adds the signed product of `op_a` and `op_b` to {HI,LO}. The product is sign-extended to 64 bits, and the sum is visible two clock edges after the command is accepted.
- R2: Op code 2 (subtract) takes the same sign-extended product away from {HI,LO}, with the same timing as R1.
- R3: Op code 3 (immediate) multiplies `op_a` by `op_imm` sign-extended to 32 bits and adds the product, with the same timing as R1.
- R4: Only the low 32 bits of the product are kept, read as a signed number. A product of 2^32 adds nothing, and a product of 2^31 counts as -2^31.
- R5: Op code 4 (read-and-clear) pulses `rd_valid` for one cycle after the accepting edge, with `rd_data` equal to LO as it was before that edge. At the same edge both HI and LO become zero.
- R6: While an accumulate product is still pending, a read-and-clear holds `op_ready` low until the sum is current. Ops 1 to 3 and unused codes never see `op_ready` low.
- R7: The sum wraps modulo 2^64, with no saturation.
- R8: `wr_en` loads `wr_data` into HI when `wr_hi` is 1 and into LO when `wr_hi` is 0, at the next edge. The other half is left untouched. In the same cycle, the write wins over a pending accumulate step or a clear, and that step or clear is dropped.
- R9: Op codes 0 and 5 to 15 leave HI and LO unchanged and never raise `rd_valid`.
- R10: Reset zeroes HI and LO, drives `rd_valid` low and leaves `op_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Command strobe |
| op_code | input | 4 | 1 add, 2 subtract, 3 immediate add, 4 read-and-clear |
| op_a | input | 32 | First multiplier operand |
| op_b | input | 32 | Second multiplier operand |
| op_imm | input | 16 | Signed immediate for op 3 |
| op_ready | output | 1 | Command accepted when high with op_valid |
| rd_valid | output | 1 | Read-and-clear result strobe |
| rd_data | output | 32 | Low half returned by read-and-clear |
| wr_en | input | 1 | Direct write strobe |
| wr_hi | input | 1 | 1 selects HI, 0 selects LO |
| wr_data | input | 32 | Direct write value |
| acc_hi | output | 32 | Accumulator high half |
| acc_lo | output | 32 | Accumulator low half |

## Verification
An accumulate changes {HI,LO} two edges after it is accepted. A read result, the clear and a direct write each appear one edge after acceptance. The bench drives and samples on falling edges and waits that exact number of edges before each comparison. The command task counts how many cycles `op_ready` stays low. This makes it possible to check that a read issued straight after an accumulate stalls for exactly one cycle. It also checks that a write timed to the accumulate edge replaces the sum.

// File: rtl/mac_acc.sv
module mac_acc #(
  parameter int DW = 32,
  parameter int IW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [CW-1:0] op_code,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [IW-1:0] op_imm,
  output logic          op_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic          wr_hi,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] acc_hi,
  output logic [DW-1:0] acc_lo
);
  localparam int AW = 2 * DW;
  localparam logic [CW-1:0] OP_ADD = CW'(1);
  localparam logic [CW-1:0] OP_SUB = CW'(2);
  localparam logic [CW-1:0] OP_IMM = CW'(3);
  localparam logic [CW-1:0] OP_RDC = CW'(4);

  logic [AW-1:0] acc;
  logic          pend, p_sub;
  logic [DW-1:0] p_val;
  logic [DW-1:0] mul_b, prod;
  logic [AW-1:0] prod_x, acc_nxt;
  logic          is_acc, is_rdc, fire;

  assign is_acc   = (op_code == OP_ADD) || (op_code == OP_SUB) || (op_code == OP_IMM);
  assign is_rdc   = (op_code == OP_RDC);
  assign op_ready = !(op_valid && is_rdc && pend);
  assign fire     = op_valid && op_ready;

  assign mul_b   = (op_code == OP_IMM) ? {{(DW-IW){op_imm[IW-1]}}, op_imm} : op_b;
  assign prod    = op_a * mul_b;
  assign prod_x  = {{DW{p_val[DW-1]}}, p_val};
  assign acc_nxt = p_sub ? acc - prod_x : acc + prod_x;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      p_sub <= 1'b0;
      p_val <= '0;
    end else begin
      pend <= fire && is_acc;
      if (fire && is_acc) begin
        p_sub <= (op_code == OP_SUB);
        p_val <= prod;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (wr_en) begin
      if (wr_hi) acc[AW-1:DW] <= wr_data;
      else       acc[DW-1:0]  <= wr_data;
    end else if (fire && is_rdc) begin
      acc <= '0;
    end else if (pend) begin
      acc <= acc_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= fire && is_rdc;
      if (fire && is_rdc) rd_data <= acc[DW-1:0];
    end
  end

  assign acc_hi = acc[AW-1:DW];
  assign acc_lo = acc[DW-1:0];
endmodule

// File: rtl/mac_acc_chk.sv
module mac_acc_chk #(
  parameter int DW = 32,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [CW-1:0] op_code,
  input logic          op_ready,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          wr_en,
  input logic          wr_hi,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] acc_hi,
  input logic [DW-1:0] acc_lo
);
  logic acc_fire, rdc_fire;
  assign acc_fire = op_valid && op_ready && (op_code >= CW'(1)) && (op_code <= CW'(3));
  assign rdc_fire = op_valid && op_ready && (op_code == CW'(4));

  AST_RDC_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rdc_fire |=> rd_valid && rd_data == $past(acc_lo)); // R5
  AST_RDC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rdc_fire && !wr_en |=> acc_hi == '0 && acc_lo == '0); // R5
  AST_RDV_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rdc_fire)); // R9
  AST_RDC_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == CW'(4) && $past(acc_fire) |-> !op_ready); // R6
  AST_NO_STALL_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code != CW'(4) |-> op_ready); // R6
  AST_WR_LO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_hi |=> acc_lo == $past(wr_data) && acc_hi == $past(acc_hi)); // R8
  AST_WR_HI: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_hi |=> acc_hi == $past(wr_data) && acc_lo == $past(acc_lo)); // R8
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && !rdc_fire && !$past(acc_fire) |=> $stable(acc_hi) && $stable(acc_lo)); // R9
endmodule

bind mac_acc mac_acc_chk #(.DW(DW), .CW(CW)) u_chk (.*);

// File: tb/test_mac_acc.sv
module test_mac_acc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [15:0] op_imm = '0;
  logic        op_ready, rd_valid;
  logic [31:0] rd_data;
  logic        wr_en = 1'b0, wr_hi = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] acc_hi, acc_lo;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  mac_acc i_mac_acc (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_a(op_a), .op_b(op_b), .op_imm(op_imm), .op_ready(op_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_en(wr_en), .wr_hi(wr_hi),
    .wr_data(wr_data), .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  typedef struct packed {
    logic [3:0]  c;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] im;
    logic [63:0] exp;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{4'd1, 32'd3,         32'd5,          16'h0000, 64'h0000000000000000F},
    '{4'd1, 32'hFFFFFFFE,  32'd10,         16'h0000, 64'hFFFFFFFF_FFFFFFFB},
    '{4'd2, 32'hFFFFFFFF,  32'hFFFFFFFF,   16'h0000, 64'hFFFFFFFF_FFFFFFFA},
    '{4'd3, 32'd7,         32'd0,          16'hFFFE, 64'hFFFFFFFF_FFFFFFEC},
    '{4'd1, 32'h00010000,  32'h00010000,   16'h0000, 64'hFFFFFFFF_FFFFFFEC},
    '{4'd1, 32'h40000000,  32'd2,          16'h0000, 64'hFFFFFFFF_7FFFFFEC},
    '{4'd2, 32'h40000000,  32'd2,          16'h0000, 64'hFFFFFFFF_FFFFFFEC},
    '{4'd3, 32'd3,         32'd0,          16'h7FFF, 64'h00000000_00017FE9},
    '{4'd5, 32'd100,       32'd100,        16'h0000, 64'h00000000_00017FE9}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, output int stalls);
    op_valid = 1'b1; op_code = c; op_a = a; op_b = b; op_imm = im; stalls = 0;
    #1;
    while (!op_ready) begin
      stalls++;
      @(negedge clk); #1;
    end
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic wr(input logic hi, input logic [31:0] d);
    wr_en = 1'b1; wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R10 acc", {acc_hi, acc_lo}, 64'd0);
    chk("R10 rd_valid", {63'd0, rd_valid}, 64'd0);
    chk("R10 op_ready", {63'd0, op_ready}, 64'd1);

    // R1 R2 R3 R4 R9 table walk
    for (int i = 0; i < 9; i++) begin
      issue(VEC[i].c, VEC[i].a, VEC[i].b, VEC[i].im, st);
      @(negedge clk);
      chk($sformatf("R1/R2/R3/R4/R9 vec %0d", i), {acc_hi, acc_lo}, VEC[i].exp);
      if (VEC[i].c > 4'd4) chk("R9 rd_valid", {63'd0, rd_valid}, 64'd0);
      chk("R6 no stall", 64'(st), 64'd0);
    end

    // R5 read-and-clear
    issue(4'd4, 32'd0, 32'd0, 16'd0, st);
    chk("R5 rd_valid", {63'd0, rd_valid}, 64'd1);
    chk("R5 rd_data", {32'd0, rd_data}, 64'h17FE9);
    chk("R5 cleared", {acc_hi, acc_lo}, 64'd0);
    @(negedge clk);
    chk("R5 pulse", {63'd0, rd_valid}, 64'd0);

    // R5 with HI nonzero
    wr(1'b1, 32'h1234);
    wr(1'b0, 32'hABCD);
    issue(4'd4, 32'd0, 32'd0, 16'd0, st);
    chk("R5 lo only", {32'd0, rd_data}, 64'hABCD);
    chk("R5 hi cleared", {acc_hi, acc_lo}, 64'd0);

    // R7 wrap
    wr(1'b1, 32'hFFFFFFFF);
    wr(1'b0, 32'hFFFFFFFF);
    chk("R8 write both", {acc_hi, acc_lo}, 64'hFFFFFFFF_FFFFFFFF);
    issue(4'd1, 32'd1, 32'd1, 16'd0, st);
    @(negedge clk);
    chk("R7 wrap", {acc_hi, acc_lo}, 64'd0);

    // R6 interlock
    issue(4'd1, 32'd6, 32'd7, 16'd0, st);
    issue(4'd4, 32'd0, 32'd0, 16'd0, st);
    chk("R6 stall cycles", 64'(st), 64'd1);
    chk("R6 read after sum", {32'd0, rd_data}, 64'd42);
    chk("R6 cleared", {acc_hi, acc_lo}, 64'd0);

    // R8 write wins over accumulate
    issue(4'd1, 32'd1, 32'd1, 16'd0, st);
    wr(1'b0, 32'h55);
    chk("R8 priority", {acc_hi, acc_lo}, 64'h55);
    @(negedge clk);
    chk("R8 dropped", {acc_hi, acc_lo}, 64'h55);
    wr(1'b1, 32'h9);
    chk("R8 hi only", {acc_hi, acc_lo}, 64'h00000009_00000055);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule